// File: doc/BRIEF.md
# Fractional SCK Profile Generator

This block produces the serial clock for a serial peripheral master from a fast reference clock, together with single-cycle strobes that tell separate shift logic when to drive out the next data bit and when to capture the incoming one. Eight timing profiles are held in the block. Each profile has a clock word, which carries a phase increment and a restart control, and a signal word, which picks the SCK edge used for launching, the edge used for sampling, and whether sampling is retimed for fast asynchronous input.

When `run` rises, the profile named by `prof_sel` is captured and used for the whole transfer. An 11-bit phase accumulator adds the profile's increment on every reference cycle. SCK changes level each time the running sum crosses a multiple of 1024, so the SCK frequency is about f_ref × increment / 2048. This allows rates that are not integer fractions of the reference. While `run` is low, SCK rests at the level given by `cpol`.

Top module: `hsck_gen`

## Requirements
- R1: After reset, `sck`, `launch_stb` and `sample_stb` are 0, and every profile holds zero. A transfer on an unwritten profile therefore produces no SCK edge.
- R2: While `run` is low, `sck` takes the value of `cpol` one reference cycle later and `launch_stb` stays low.
- R3: On each reference cycle with `run` high, the accumulator adds the increment modulo 2048. `sck` changes level in the same cycle in which the sum crosses a multiple of 1024. With the restart control set, N running cycles give floor(N × inc / 1024) SCK edges.
- R4: An increment of 0 keeps `sck` at its idle level for the whole transfer. Any increment above 1024 acts as 1024, which is one SCK edge per reference cycle.
- R5: With the restart bit (clock word bit 15) set, the accumulator restarts from zero on the first running cycle, so the first edge comes on running cycle ceil(1024 / inc). With the bit clear, the accumulator continues from the value the previous transfer left.
- R6: `launch_stb` pulses for one cycle, in the cycle in which `sck` changes to 1 if signal word bit 13 is set, or to 0 if that bit is clear.
- R7: `sample_stb` follows the same rule using signal word bit 12.
- R8: With signal word bit 16 set, each `sample_stb` pulse comes one reference cycle after its SCK edge instead of in the same cycle, including the pulse for the last edge of a transfer.
- R9: The profile is captured in the first running cycle. Later changes of `prof_sel` during the transfer have no effect.
- R10: A write with `cfg_we` high stores `cfg_wdata` into profile `cfg_prof`. When `cfg_word` is 0 the target is the clock word (increment in bits 13:0, restart in bit 15). When `cfg_word` is 1 the target is the signal word (bits 12, 13 and 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Profile word write enable |
| cfg_prof | input | 3 | Profile being written |
| cfg_word | input | 1 | 0 selects the clock word, 1 selects the signal word |
| cfg_wdata | input | 32 | Write data |
| run | input | 1 | High while a transfer runs |
| prof_sel | input | 3 | Profile for the transfer, captured at its start |
| cpol | input | 1 | Idle level of SCK |
| sck | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle pulse on the launch edge |
| sample_stb | output | 1 | One-cycle pulse on the sample edge, delayed one cycle when retimed |

## Verification
A wrong accumulator value does not show at the ports straight away. It appears as a first SCK edge on the wrong running cycle, and over a longer window as a wrong edge count. The checks therefore compare both the cycle of the first edge and the total number of edges, and they run two transfers back to back with the restart bit clear so that any value left in the accumulator shows up. A wrongly captured profile or edge-select bit appears within one SCK period as strobes that miss their edge or fall on the opposite edge. The bench checks the position of every strobe against the SCK transitions and counts the strobes.

// File: rtl/hsck_pkg.sv
package hsck_pkg;

    localparam int PROF_N = 8;
    localparam int INC_W  = 14;
    localparam int ACC_W  = 11;

    // bit positions inside the written words
    localparam int B_RESTART     = 15;
    localparam int B_SAMPLE_RISE = 12;
    localparam int B_LAUNCH_RISE = 13;
    localparam int B_RETIME      = 16;

    localparam logic [INC_W-1:0] HALF_INC = INC_W'(1 << (ACC_W - 1));

    typedef struct packed {
        logic [INC_W-1:0] inc;
        logic             restart;
    } clk_word_t;

    typedef struct packed {
        logic sample_rise;
        logic launch_rise;
        logic retime;
    } sig_word_t;

    typedef struct packed {
        clk_word_t ck;
        sig_word_t sg;
    } prof_t;

    function automatic clk_word_t unpack_clk(input logic [31:0] w);
        clk_word_t r;
        r.inc     = w[INC_W-1:0];
        r.restart = w[B_RESTART];
        return r;
    endfunction

    function automatic sig_word_t unpack_sig(input logic [31:0] w);
        sig_word_t r;
        r.sample_rise = w[B_SAMPLE_RISE];
        r.launch_rise = w[B_LAUNCH_RISE];
        r.retime      = w[B_RETIME];
        return r;
    endfunction

    // steps above half the modulus would skip a boundary: limit them
    function automatic logic [ACC_W-1:0] limit_step(input logic [INC_W-1:0] v);
        if (v > HALF_INC) return HALF_INC[ACC_W-1:0];
        return v[ACC_W-1:0];
    endfunction

endpackage

// File: rtl/hsck_profile_bank.sv
module hsck_profile_bank
    import hsck_pkg::*;
#(
    parameter int NPROF = PROF_N,
    localparam int SEL_W = $clog2(NPROF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             word_sel,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic [31:0]      wdata,
    input  logic [SEL_W-1:0] rd_idx,
    output prof_t            rd_data
);

    prof_t table_q [NPROF];

    for (genvar g = 0; g < NPROF; g++) begin : g_prof
        prof_t slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (we && wr_idx == SEL_W'(g)) begin
                if (word_sel) slot_q.sg <= unpack_sig(wdata);
                else          slot_q.ck <= unpack_clk(wdata);
            end
        end
        assign table_q[g] = slot_q;
    end

    assign rd_data = table_q[rd_idx];

endmodule

// File: rtl/hsck_phase_acc.sv
module hsck_phase_acc
    import hsck_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             first,
    input  logic             restart,
    input  logic [INC_W-1:0] inc,
    output logic             edge_hit
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] sum;

    always_comb begin
        base     = (first && restart) ? '0 : acc_q;
        step     = limit_step(inc);
        sum      = base + step;
        edge_hit = run && (sum[ACC_W-1] != base[ACC_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst)      acc_q <= '0;
        else if (run) acc_q <= sum;
    end

endmodule

// File: rtl/hsck_strobe_gen.sv
module hsck_strobe_gen
    import hsck_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      cpol,
    input  logic      edge_hit,
    input  sig_word_t sg,
    output logic      sck,
    output logic      launch_stb,
    output logic      sample_stb
);

    logic sck_q, launch_q, sample_q, late_q;
    logic next_lvl, fire, want_sample;

    always_comb begin
        next_lvl    = ~sck_q;
        fire        = run && edge_hit;
        want_sample = fire && (next_lvl == sg.sample_rise);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            launch_q <= 1'b0;
            sample_q <= 1'b0;
            late_q   <= 1'b0;
        end else begin
            if (!run)      sck_q <= cpol;
            else if (fire) sck_q <= next_lvl;
            launch_q <= fire && (next_lvl == sg.launch_rise);
            late_q   <= want_sample && sg.retime;
            sample_q <= (want_sample && !sg.retime) || late_q;
        end
    end

    assign sck        = sck_q;
    assign launch_stb = launch_q;
    assign sample_stb = sample_q;

endmodule

// File: rtl/hsck_gen.sv
module hsck_gen
    import hsck_pkg::*;
#(
    parameter int NPROF = PROF_N,
    localparam int SEL_W = $clog2(NPROF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_prof,
    input  logic             cfg_word,
    input  logic [31:0]      cfg_wdata,
    input  logic             run,
    input  logic [SEL_W-1:0] prof_sel,
    input  logic             cpol,
    output logic             sck,
    output logic             launch_stb,
    output logic             sample_stb
);

    logic             run_q;
    logic [SEL_W-1:0] held_q;
    logic             first;
    logic [SEL_W-1:0] use_idx;
    prof_t            act;
    logic             edge_hit;

    assign first   = run && !run_q;
    assign use_idx = first ? prof_sel : held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            held_q <= '0;
        end else begin
            run_q <= run;
            if (first) held_q <= prof_sel;
        end
    end

    hsck_profile_bank #(.NPROF(NPROF)) i_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .word_sel (cfg_word),
        .wr_idx   (cfg_prof),
        .wdata    (cfg_wdata),
        .rd_idx   (use_idx),
        .rd_data  (act)
    );

    hsck_phase_acc i_acc (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .first    (first),
        .restart  (act.ck.restart),
        .inc      (act.ck.inc),
        .edge_hit (edge_hit)
    );

    hsck_strobe_gen i_stb (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .cpol       (cpol),
        .edge_hit   (edge_hit),
        .sg         (act.sg),
        .sck        (sck),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb)
    );

endmodule

// File: rtl/hsck_gen_chk.sv
module hsck_gen_chk (
    input logic clk,
    input logic rst,
    input logic run,
    input logic cpol,
    input logic sck,
    input logic launch_stb,
    input logic sample_stb
);

    p_idle_follow_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(run)) |-> (sck == $past(cpol)));

    p_no_launch_idle_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(run)) |-> !launch_stb);

    p_edge_only_running_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && sck != $past(sck)) |-> ($past(run) || sck == $past(cpol)));

    p_launch_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && launch_stb) |-> (sck != $past(sck)));

    p_sample_near_edge_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2) && sample_stb) |->
            ((sck != $past(sck)) || ($past(sck) != $past(sck, 2))));

endmodule

bind hsck_gen hsck_gen_chk i_chk (.*);

// File: tb/test_hsck_gen.sv
module test_hsck_gen;

    typedef struct packed {
        logic [2:0]  prof;
        logic [13:0] inc;
        logic        smp_r;
        logic        lau_r;
        logic        rtm;
        logic        cp;
        logic [7:0]  n;
        logic [7:0]  edges;
        logic [7:0]  first;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 14'd256,  1'b1, 1'b0, 1'b0, 1'b0, 8'd40, 8'd10, 8'd4},
        '{3'd3, 14'd100,  1'b0, 1'b1, 1'b0, 1'b1, 8'd60, 8'd5,  8'd11},
        '{3'd7, 14'd1024, 1'b1, 1'b1, 1'b0, 1'b0, 8'd9,  8'd9,  8'd1},
        '{3'd5, 14'd2000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd7,  8'd7,  8'd1},
        '{3'd2, 14'd0,    1'b1, 1'b0, 1'b0, 1'b1, 8'd20, 8'd0,  8'd0},
        '{3'd4, 14'd384,  1'b1, 1'b0, 1'b1, 1'b0, 8'd30, 8'd11, 8'd3},
        '{3'd6, 14'd700,  1'b0, 1'b1, 1'b1, 1'b1, 8'd25, 8'd17, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_prof = '0;
    logic        cfg_word = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        run = 1'b0;
    logic [2:0]  prof_sel = '0;
    logic        cpol = 1'b0;
    logic        sck, launch_stb, sample_stb;

    int n_cmp = 0;
    int n_bad = 0;

    // per-transfer measurements
    int m_edges, m_first, m_launch, m_sample, m_align;
    logic c_lau, c_smp, c_rtm;

    always #2.5ns clk = ~clk;

    hsck_gen i_hsck_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_prof(cfg_prof),
        .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .run(run),
        .prof_sel(prof_sel), .cpol(cpol), .sck(sck),
        .launch_stb(launch_stb), .sample_stb(sample_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] p, input logic w, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_prof = p; cfg_word = w; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [2:0] p, input logic [13:0] inc, input logic rs,
                         input logic s, input logic l, input logic r);
        wr(p, 1'b0, (32'(rs) << 15) | 32'(inc));
        wr(p, 1'b1, (32'(s) << 12) | (32'(l) << 13) | (32'(r) << 16));
        c_smp = s; c_lau = l; c_rtm = r;
    endtask

    // run n cycles; at cycle sw_at (if nonzero) switch prof_sel to sw_to
    task automatic xfer(input int n, input int sw_at, input logic [2:0] sw_to);
        logic prev, prev_chg, chg, exp_s;
        m_edges = 0; m_first = 0; m_launch = 0; m_sample = 0; m_align = 0;
        prev = sck; prev_chg = 1'b0;
        @(negedge clk);
        run = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            chg = (sck != prev);
            if (chg) begin
                m_edges++;
                if (m_first == 0) m_first = i;
            end
            if (launch_stb) begin
                m_launch++;
                if (!(chg && sck == c_lau)) m_align++;
            end
            exp_s = c_rtm ? (prev_chg && prev == c_smp) : (chg && sck == c_smp);
            if (sample_stb) m_sample++;
            if (sample_stb != exp_s) m_align++;
            prev_chg = chg;
            prev = sck;
            if (i == sw_at) prof_sel = sw_to;
        end
        run = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (sample_stb) m_sample++;
            if (launch_stb) m_align++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; run = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(5ns * 150000);
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(sck == 1'b0, "R1 sck in reset", sck, 0);
        chk(launch_stb == 1'b0, "R1 launch in reset", launch_stb, 0);
        chk(sample_stb == 1'b0, "R1 sample in reset", sample_stb, 0);
        rst = 1'b0;
        @(negedge clk);
        c_lau = 0; c_smp = 0; c_rtm = 0; prof_sel = 3'd6;
        xfer(20, 0, 3'd0);
        chk(m_edges == 0, "R1 unwritten profile edges", m_edges, 0);

        // table of vectors (R3 R4 R6 R7 R8 R10)
        foreach (VECS[v]) begin
            int e, rise, exp_l, exp_s;
            setup(VECS[v].prof, VECS[v].inc, 1'b1, VECS[v].smp_r, VECS[v].lau_r, VECS[v].rtm);
            prof_sel = VECS[v].prof;
            cpol = VECS[v].cp;
            repeat (2) @(negedge clk);
            xfer(int'(VECS[v].n), 0, 3'd0);
            e = int'(VECS[v].edges);
            rise = VECS[v].cp ? e / 2 : (e + 1) / 2;
            exp_l = VECS[v].lau_r ? rise : e - rise;
            exp_s = VECS[v].smp_r ? rise : e - rise;
            chk(m_edges == e, $sformatf("R3/R4 edge count v%0d", v), m_edges, e);
            chk(m_first == int'(VECS[v].first), $sformatf("R5 first edge v%0d", v),
                m_first, int'(VECS[v].first));
            chk(m_launch == exp_l, $sformatf("R6 launch count v%0d", v), m_launch, exp_l);
            chk(m_sample == exp_s, $sformatf("R7 sample count v%0d", v), m_sample, exp_s);
            chk(m_align == 0, $sformatf("R8 strobe alignment v%0d", v), m_align, 0);
        end

        // R5: accumulator carries over when the restart bit is clear
        do_reset();
        cpol = 1'b0; prof_sel = 3'd0;
        setup(3'd0, 14'd256, 1'b0, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        xfer(6, 0, 3'd0);
        chk(m_first == 4, "R5 first edge from reset value", m_first, 4);
        repeat (2) @(negedge clk);
        xfer(6, 0, 3'd0);
        chk(m_first == 2, "R5 first edge continues without restart", m_first, 2);
        setup(3'd0, 14'd256, 1'b1, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        xfer(6, 0, 3'd0);
        chk(m_first == 4, "R5 first edge with restart", m_first, 4);

        // R9: prof_sel change mid transfer ignored
        setup(3'd2, 14'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        setup(3'd1, 14'd512, 1'b1, 1'b1, 1'b0, 1'b0);
        prof_sel = 3'd1;
        repeat (2) @(negedge clk);
        xfer(10, 2, 3'd2);
        chk(m_edges == 5, "R9 edges after prof_sel change", m_edges, 5);
        chk(m_align == 0, "R9 strobe alignment", m_align, 0);

        // R2: idle level follows cpol one cycle later, no strobes
        @(negedge clk);
        cpol = 1'b1;
        @(negedge clk);
        chk(sck == 1'b1, "R2 idle sck follows cpol high", sck, 1);
        chk(launch_stb == 1'b0, "R2 no launch while idle", launch_stb, 0);
        cpol = 1'b0;
        @(negedge clk);
        chk(sck == 1'b0, "R2 idle sck follows cpol low", sck, 0);
        chk(sample_stb == 1'b0, "R2 no sample while idle", sample_stb, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule